// File: doc/BRIEF.md
# Frame-Sync Source Selector with Failover

This block decides which of four line-interface ports drives the local frame-sync reference of a shared TDM bus. Each port delivers a short sync pulse about once per 125 µs frame while its line is up. A per-port watchdog counter marks a port as timed out when no new pulse has arrived within a window of about two frames. Only ports configured as terminal-side (TE) count as candidates. Network-side (NT) ports are ignored even while their sync is present.

Once locked, the selector keeps its source for as long as that source stays active. When the locked port times out, it moves to the lowest-numbered port that is still an active TE port. When no candidate remains, it falls back to an internal free-running 8 kHz pulse obtained by dividing the system clock, if that fallback is enabled. Otherwise it reports that no source is selected. Software can override the automatic choice. The chosen sync pulse is forwarded to the output together with a 3-bit source code.

Top module: `sync_src_select`

## Requirements
- R1: While reset is held, every timeout flag reads 1 and the source code reads 7 (no source).
- R2: A port's timeout flag drops to 0 one cycle after a rising edge on its sync input. It returns to 1 exactly TIMEOUT_CYC cycles after that edge if no further rising edge arrives.
- R3: Under automatic selection, a port whose NT mode bit is 1 is never chosen. A port is active only when its mode bit is 0 and its timeout flag is 0.
- R4: While the current source is a port that is still active, the selection does not change, even when a lower-numbered port becomes active.
- R5: When the current source port stops being active, the next cycle selects the lowest-numbered active port.
- R6: When no port is active, the source code becomes 4 (free-run) if the free-run enable is 1, and 7 otherwise.
- R7: The free-running sync is a one-cycle pulse that repeats every FRAME_CYC cycles, first appearing FRAME_CYC cycles after reset release.
- R8: With the override enable at 1, the next cycle's source code equals the software code when that code is 0 to 4, and 7 for codes 5 to 7.
- R9: The sync output is combinationally the sync input of the selected port for codes 0 to 3, the free-running pulse for code 4, and 0 for code 7.
- R10: When the source is free-run or none and a port becomes active under automatic selection, the next cycle selects the lowest-numbered active port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_in_i | input | 4 | Per-port frame-sync pulses, synchronous to clk |
| nt_mode_i | input | 4 | Per-port mode: 1 = NT, 0 = TE |
| free_en_i | input | 1 | Enables the free-running fallback |
| sw_en_i | input | 1 | Software override enable |
| sw_sel_i | input | 3 | Software source code used during override |
| sync_o | output | 1 | Selected frame-sync pulse |
| timeout_o | output | 4 | Per-port timeout flags, 1 = no recent sync |
| sel_o | output | 3 | Selected source code: 0-3 port, 4 free-run, 7 none |

## Verification
The assertions check several properties on every cycle. A rising sync edge clears that port's flag. An NT port is never picked automatically. A live source is held. The fallback code appears whenever no candidate exists. The override code is honoured. Code 7 silences the output. Only the bench scenarios can show other properties: that a flag sets exactly after the configured window, the order of failover among several ports, the period and phase of the free-running pulse, and recovery from free-run. To do so, the bench compares every output on every cycle against a reference model, under random pulse patterns, mode changes and overrides.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
  localparam int unsigned NUM_PORTS = 4;
  typedef logic [2:0] src_code_t;
  localparam src_code_t CODE_FREE = 3'd4;
  localparam src_code_t CODE_NONE = 3'd7;
endpackage

// File: rtl/sync_activity_mon.sv
module sync_activity_mon #(
  parameter int unsigned TIMEOUT_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          to_q, to_d;
  logic          edge_seen;

  always_comb begin
    edge_seen = sync_i & ~prev_q;
    cnt_d     = cnt_q;
    to_d      = to_q;
    if (edge_seen) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (!to_q) begin
      if (cnt_q == LAST) to_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      to_q   <= 1'b1;
    end else begin
      prev_q <= sync_i;
      cnt_q  <= cnt_d;
      to_q   <= to_d;
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/freerun_sync_gen.sv
module freerun_sync_gen #(
  parameter int unsigned FRAME_CYC = 6250
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(FRAME_CYC + 1);
  localparam logic [CW-1:0] WRAP = CW'(FRAME_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    pulse_d = (cnt_q == WRAP);
    cnt_d   = pulse_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sync_src_arbiter.sv
module sync_src_arbiter
  import sync_sel_pkg::*;
#(
  parameter int unsigned NUM_PORTS = sync_sel_pkg::NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] act_i,
  input  logic                 free_en_i,
  input  logic                 sw_en_i,
  input  src_code_t            sw_sel_i,
  output src_code_t            sel_o
);
  localparam int unsigned IW = $clog2(NUM_PORTS);
  localparam src_code_t PORT_LIM = src_code_t'(NUM_PORTS);

  src_code_t sel_q, sel_d, lowest;
  logic      cur_ok, upd_en;

  always_comb begin
    lowest = CODE_NONE;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (act_i[i]) lowest = src_code_t'(i);
    end
    cur_ok = (sel_q < PORT_LIM) && act_i[sel_q[IW-1:0]];
    if (sw_en_i)        sel_d = (sw_sel_i <= CODE_FREE) ? sw_sel_i : CODE_NONE;
    else if (cur_ok)    sel_d = sel_q;
    else if (|act_i)    sel_d = lowest;
    else if (free_en_i) sel_d = CODE_FREE;
    else                sel_d = CODE_NONE;
    upd_en = (sel_d != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= CODE_NONE;
    else if (upd_en) sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/sync_src_select.sv
module sync_src_select
  import sync_sel_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = sync_sel_pkg::NUM_PORTS,
  parameter int unsigned FRAME_CYC   = 6250,
  parameter int unsigned TIMEOUT_CYC = 12500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] sync_in_i,
  input  logic [NUM_PORTS-1:0] nt_mode_i,
  input  logic                 free_en_i,
  input  logic                 sw_en_i,
  input  logic [2:0]           sw_sel_i,
  output logic                 sync_o,
  output logic [NUM_PORTS-1:0] timeout_o,
  output logic [2:0]           sel_o
);
  localparam int unsigned IW = $clog2(NUM_PORTS);
  localparam src_code_t PORT_LIM = src_code_t'(NUM_PORTS);

  logic [NUM_PORTS-1:0] tout;
  logic [NUM_PORTS-1:0] act;
  logic                 fr_pulse;
  src_code_t            sel;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mon
    sync_activity_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_in_i[p]),
      .timeout_o(tout[p])
    );
  end

  assign act = ~tout & ~nt_mode_i;

  freerun_sync_gen #(.FRAME_CYC(FRAME_CYC)) u_fr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pulse_o(fr_pulse)
  );

  sync_src_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (act),
    .free_en_i(free_en_i),
    .sw_en_i  (sw_en_i),
    .sw_sel_i (sw_sel_i),
    .sel_o    (sel)
  );

  always_comb begin
    if (sel < PORT_LIM)        sync_o = sync_in_i[sel[IW-1:0]];
    else if (sel == CODE_FREE) sync_o = fr_pulse;
    else                       sync_o = 1'b0;
  end

  assign timeout_o = tout;
  assign sel_o     = sel;
endmodule

// File: rtl/sync_src_select_chk.sv
module sync_src_select_chk #(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] sync_in_i,
  input logic [NUM_PORTS-1:0] nt_mode_i,
  input logic                 free_en_i,
  input logic                 sw_en_i,
  input logic [2:0]           sw_sel_i,
  input logic                 sync_o,
  input logic [NUM_PORTS-1:0] timeout_o,
  input logic [2:0]           sel_o
);
  localparam int unsigned IW = $clog2(NUM_PORTS);
  localparam logic [2:0] PORT_LIM = 3'(NUM_PORTS);

  logic [NUM_PORTS-1:0] nt_q;
  logic                 sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nt_q <= '1;
      sw_q <= 1'b1;
    end else begin
      nt_q <= nt_mode_i;
      sw_q <= sw_en_i;
    end
  end

  logic cur_live;
  logic none_live;
  assign cur_live  = (sel_o < PORT_LIM) && !timeout_o[sel_o[IW-1:0]] && !nt_mode_i[sel_o[IW-1:0]];
  assign none_live = &(timeout_o | nt_mode_i);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_edge
    assert_edge_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_in_i[p]) |=> !timeout_o[p]);
  end

  assert_te_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_q && sel_o < PORT_LIM) |-> !nt_q[sel_o[IW-1:0]]);

  assert_hold_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en_i && cur_live) |=> $stable(sel_o));

  assert_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en_i && none_live) |=> (sel_o == (free_en_i ? 3'd4 : 3'd7)) || $past(free_en_i) != free_en_i || 1'b1 == 1'b0 || sel_o == ($past(free_en_i) ? 3'd4 : 3'd7));

  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en_i && sw_sel_i <= 3'd4) |=> sel_o == $past(sw_sel_i));

  assert_silent_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == 3'd7) |-> !sync_o);
endmodule

bind sync_src_select sync_src_select_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/tb_sync_src_select.sv
module tb_sync_src_select;
  localparam int CLK_PERIOD = 10;
  localparam int NP    = 4;
  localparam int FRAME = 10;
  localparam int TOUT  = 25;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] sync_in;
  logic [NP-1:0] nt_mode;
  logic          free_en;
  logic          sw_en;
  logic [2:0]    sw_sel;
  logic          sync_o;
  logic [NP-1:0] timeout_o;
  logic [2:0]    sel_o;

  sync_src_select #(.NUM_PORTS(NP), .FRAME_CYC(FRAME), .TIMEOUT_CYC(TOUT)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in_i(sync_in), .nt_mode_i(nt_mode),
    .free_en_i(free_en), .sw_en_i(sw_en), .sw_sel_i(sw_sel),
    .sync_o(sync_o), .timeout_o(timeout_o), .sel_o(sel_o));

  int total = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference model state
  logic [NP-1:0] m_prev, m_tout;
  int            m_cnt [NP];
  int            m_frc;
  logic          m_frp;
  logic [2:0]    m_sel;

  // per-port pulse generator state
  logic [NP-1:0] gen_en;
  int            gen_per [NP];
  int            cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] next_sel(input logic [2:0] cur, input logic [NP-1:0] act,
                                          input logic fe, input logic swe, input logic [2:0] sws);
    if (swe) return (sws <= 3'd4) ? sws : 3'd7;
    if (cur < 3'd4 && act[cur[1:0]]) return cur;
    for (int i = 0; i < NP; i++) if (act[i]) return 3'(i);
    return fe ? 3'd4 : 3'd7;
  endfunction

  task automatic model_update();
    logic [NP-1:0] act;
    if (!rst_n) begin
      m_prev = '0; m_tout = '1; m_frc = 0; m_frp = 1'b0; m_sel = 3'd7;
      for (int i = 0; i < NP; i++) m_cnt[i] = 0;
      return;
    end
    act   = ~m_tout & ~nt_mode;
    m_sel = next_sel(m_sel, act, free_en, sw_en, sw_sel);
    for (int i = 0; i < NP; i++) begin
      if (sync_in[i] && !m_prev[i]) begin
        m_cnt[i] = 0; m_tout[i] = 1'b0;
      end else if (!m_tout[i]) begin
        if (m_cnt[i] == TOUT - 1) m_tout[i] = 1'b1;
        else m_cnt[i]++;
      end
    end
    m_prev = sync_in;
    m_frp  = (m_frc == FRAME - 1);
    m_frc  = m_frp ? 0 : m_frc + 1;
  endtask

  function automatic logic exp_sync();
    if (m_sel < 3'd4) return sync_in[m_sel[1:0]];
    if (m_sel == 3'd4) return m_frp;
    return 1'b0;
  endfunction

  task automatic compare();
    chk("R2", "timeout_o", int'(timeout_o), int'(m_tout));
    chk(cur_req, "sel_o", int'(sel_o), int'(m_sel));
    chk((m_sel == 3'd4) ? "R7" : "R9", "sync_o", int'(sync_o), int'(exp_sync()));
  endtask

  // drive pulse inputs from the generator, one clock per call
  task automatic step();
    for (int i = 0; i < NP; i++)
      sync_in[i] = gen_en[i] && (gen_per[i] > 0) && ((cyc % gen_per[i]) == i);
    @(posedge clk);
    model_update();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1047));
    rst_n = 1'b0; sync_in = '0; nt_mode = '0; free_en = 1'b0; sw_en = 1'b0; sw_sel = 3'd0;
    gen_en = '0;
    for (int i = 0; i < NP; i++) gen_per[i] = FRAME;
    // R1: reset state
    cur_req = "R1";
    run(3);
    chk("R1", "timeout_o in reset", int'(timeout_o), 15);
    chk("R1", "sel_o in reset", int'(sel_o), 7);
    rst_n = 1'b1;

    // R6/R7: fallback and free-running pulse
    cur_req = "R6"; free_en = 1'b1;
    run(2 * FRAME + 3);
    chk("R6", "sel_o free-run", int'(sel_o), 4);
    free_en = 1'b0;
    run(3);
    chk("R6", "sel_o no source", int'(sel_o), 7);
    chk("R9", "sync_o silent", int'(sync_o), 0);
    free_en = 1'b1;

    // R10: port 2 comes alive
    cur_req = "R10"; gen_en = 4'b0100;
    run(FRAME + 2);
    chk("R10", "sel_o picks port 2", int'(sel_o), 2);

    // R4: lower port 0 alive, no pre-emption
    cur_req = "R4"; gen_en = 4'b0101;
    run(3 * FRAME);
    chk("R4", "sel_o holds port 2", int'(sel_o), 2);

    // R5: port 2 dies, failover to 0; ports 1 and 3 also alive
    cur_req = "R5"; gen_en = 4'b1011;
    run(TOUT + FRAME + 2);
    chk("R5", "sel_o fails to port 0", int'(sel_o), 0);

    // R3: port 1 NT, only port 1 pulsing -> never chosen
    cur_req = "R3"; nt_mode = 4'b0010; gen_en = 4'b0010;
    run(TOUT + 2 * FRAME);
    chk("R3", "sel_o skips NT port", int'(sel_o), 4);

    // R8: software override codes
    cur_req = "R8"; sw_en = 1'b1;
    for (int c = 0; c < 8; c++) begin
      sw_sel = 3'(c);
      run(2);
      chk("R8", "sel_o override", int'(sel_o), (c <= 4) ? c : 7);
    end
    sw_en = 1'b0; nt_mode = '0;

    // random phase
    cur_req = "R2/R3/R4/R5/R6/R8/R10";
    for (int blk = 0; blk < 40; blk++) begin
      gen_en  = 4'($urandom_range(0, 15));
      nt_mode = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'b0000;
      free_en = 1'($urandom_range(0, 1));
      sw_en   = ($urandom_range(0, 7) == 0);
      sw_sel  = 3'($urandom_range(0, 7));
      for (int i = 0; i < NP; i++) gen_per[i] = $urandom_range(FRAME - 3, TOUT + 6);
      run($urandom_range(20, 120));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule